// File: doc/BRIEF.md
# Protected Clock Control Register

This block keeps three clock-control bits behind a software key. They are the low-speed oscillator enable, the CPU clock source select and the halt-mode option. A byte-wide register port reaches them through two control addresses and a third address for the key register. Each write to a control address is honoured only while the key register holds the unlock value 0x96. A write made while the key does not match is dropped without any indication.

Two interlocks guard the CPU clock. The low-speed oscillator cannot be stopped while the CPU runs from it. The clock source changes only while both oscillators run. A move onto the low-speed clock also waits until that clock is reported stable.

After the low-speed oscillator is enabled, a counter advances on each reference tick. The stable status rises after a parameterized number of ticks. The counter also runs out of reset, because the oscillator is on from reset.

Top module: `protclk_ctrl`

## Requirements
- R1: After reset the outputs are lso_en=1, clk_sel_hs=1, halt2_mode=0 and lso_stable=0, and the key register reads 0x00.
- R2: A write to the power address (0) or the option address (1) changes nothing unless the key register holds 0x96 at the time of the write.
- R3: When unlocked, bit 0 written to the power address sets lso_en (1 = run, 0 = stop), and bit 0 of a power-address read returns lso_en.
- R4: While clk_sel_hs is 0, or while the same write moves clk_sel_hs to 0, writing 0 to bit 0 of the power address leaves lso_en at 1.
- R5: Bit 2 of the power address selects the CPU clock (1 = high-speed, 0 = low-speed) and reads back clk_sel_hs. A change is accepted only while hs_osc_on and lso_en are both 1.
- R6: A change of clk_sel_hs from 1 to 0 is also refused while lso_stable is 0.
- R7: When unlocked, bit 3 written to the option address (1) sets halt2_mode (1 = second halt mode, 0 = basic), and bit 3 of an option-address read returns it.
- R8: lso_stable rises on the clock edge after the SETTLE_TICKS-th ref_tick seen while lso_en is 1. It falls one cycle after lso_en goes to 0, and counting starts over from zero when lso_en returns to 1.
- R9: The key register at address 2 can be written and read at any time, and writes to the other addresses leave it unchanged.
- R10: Unused bits of the power and option addresses read 0, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address (0 power, 1 option, 2 key) |
| bus_we | input | 1 | Write strobe, one cycle per byte write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| ref_tick | input | 1 | Reference tick that advances the stabilization counter |
| hs_osc_on | input | 1 | High-speed oscillator is running |
| lso_en | output | 1 | Low-speed oscillator enable |
| clk_sel_hs | output | 1 | CPU clock select, 1 = high-speed |
| halt2_mode | output | 1 | Halt-mode option to the halt logic |
| lso_stable | output | 1 | Low-speed clock has stabilized |

## Verification
The bench sweeps all 256 key values. For each value it tries an option write and a power write, then reads back both the target register and the key. A design that compared only part of the key would accept wrong keys, and one that cleared the key on a protected write would show it as lost. A set of directed writes tests each interlock:
- stopping the low-speed oscillator while it clocks the CPU,
- switching while the high-speed oscillator is off,
- switching while the low-speed oscillator is off,
- switching onto a clock that is not yet stable,
- a single write that both moves to the low-speed clock and stops that oscillator.

A design with a wrong interlock would accept one of these writes and leave the CPU on a dead or unsettled clock. The bench counts ticks to check that stable rises on exactly the programmed tick and starts over after a stop and restart. An off-by-one design would rise one tick early or late, and a counter that was not cleared would rise too soon.

// File: rtl/protclk_pkg.sv
package protclk_pkg;
   localparam logic [7:0] UNLOCK_KEY = 8'h96;
   localparam int OSC_BIT  = 0;
   localparam int SEL_BIT  = 2;
   localparam int HALT_BIT = 3;
endpackage

// File: rtl/protclk_key_reg.sv
module protclk_key_reg #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY_VAL = DATA_W'(8'h96)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] key_q,
   output logic              open_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      key_q <= '0;
      else if (wr_stb) key_q <= wdata;
   end

   assign open_o = (key_q == KEY_VAL);
endmodule

// File: rtl/protclk_settle_cnt.sv
module protclk_settle_cnt #(
   parameter int TICKS = 98304
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en,
   input  logic ref_tick,
   output logic stable_o
);
   localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         stable_o <= 1'b0;
      end else if (!osc_en) begin
         cnt_q    <= '0;
         stable_o <= 1'b0;
      end else if (ref_tick && !stable_o) begin
         if (cnt_q == LAST) stable_o <= 1'b1;
         else               cnt_q    <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/protclk_rd_mux.sv
module protclk_rd_mux #(
   parameter int ADDR_W   = 2,
   parameter int DATA_W   = 8,
   parameter int PWR_ADDR = 0,
   parameter int OPT_ADDR = 1,
   parameter int KEY_ADDR = 2,
   parameter bit RD_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] pwr_val,
   input  logic [DATA_W-1:0] opt_val,
   input  logic [DATA_W-1:0] key_val,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] sel_d;

   always_comb begin
      if (addr == ADDR_W'(PWR_ADDR))      sel_d = pwr_val;
      else if (addr == ADDR_W'(OPT_ADDR)) sel_d = opt_val;
      else if (addr == ADDR_W'(KEY_ADDR)) sel_d = key_val;
      else                                sel_d = '0;
   end

   generate
      if (RD_REG) begin : g_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= sel_d;
         end
         assign rdata = rd_q;
      end else begin : g_comb
         assign rdata = sel_d;
      end
   endgenerate
endmodule

// File: rtl/protclk_ctrl.sv
module protclk_ctrl #(
   parameter int ADDR_W       = 2,
   parameter int DATA_W       = 8,
   parameter int PWR_ADDR     = 0,
   parameter int OPT_ADDR     = 1,
   parameter int KEY_ADDR     = 2,
   parameter int SETTLE_TICKS = 98304,
   parameter bit RD_REG       = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ref_tick,
   input  logic              hs_osc_on,
   output logic              lso_en,
   output logic              clk_sel_hs,
   output logic              halt2_mode,
   output logic              lso_stable
);
   import protclk_pkg::*;

   generate
      if (DATA_W < 8) begin : g_bad_w
         $error("DATA_W must hold the 8-bit key");
      end
      if (SETTLE_TICKS < 1) begin : g_bad_t
         $error("SETTLE_TICKS must be at least 1");
      end
      if (PWR_ADDR == OPT_ADDR || PWR_ADDR == KEY_ADDR || OPT_ADDR == KEY_ADDR) begin : g_bad_a
         $error("register addresses must differ");
      end
      if (KEY_ADDR >= (1 << ADDR_W) || PWR_ADDR >= (1 << ADDR_W) || OPT_ADDR >= (1 << ADDR_W)) begin : g_bad_r
         $error("address outside ADDR_W range");
      end
   endgenerate

   logic [DATA_W-1:0] key_val;
   logic key_open;
   logic key_wr, pwr_wr, opt_wr;
   logic osc_q, sel_q, halt_q;
   logic osc_nx, sel_nx, halt_nx, sel_req, sel_ok;
   logic [DATA_W-1:0] pwr_view, opt_view;

   assign key_wr = bus_we && (bus_addr == ADDR_W'(KEY_ADDR));
   assign pwr_wr = bus_we && (bus_addr == ADDR_W'(PWR_ADDR)) && key_open;
   assign opt_wr = bus_we && (bus_addr == ADDR_W'(OPT_ADDR)) && key_open;

   protclk_key_reg #(
      .DATA_W (DATA_W),
      .KEY_VAL(DATA_W'(UNLOCK_KEY))
   ) u_key (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_stb(key_wr),
      .wdata (bus_wdata),
      .key_q (key_val),
      .open_o(key_open)
   );

   always_comb begin
      sel_req = bus_wdata[SEL_BIT];
      sel_ok  = hs_osc_on && osc_q && (sel_req || lso_stable);
      sel_nx  = (pwr_wr && sel_ok) ? sel_req : sel_q;
      osc_nx  = pwr_wr ? (bus_wdata[OSC_BIT] | ~sel_nx) : osc_q;
      halt_nx = opt_wr ? bus_wdata[HALT_BIT] : halt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_q  <= 1'b1;
         sel_q  <= 1'b1;
         halt_q <= 1'b0;
      end else begin
         osc_q  <= osc_nx;
         sel_q  <= sel_nx;
         halt_q <= halt_nx;
      end
   end

   protclk_settle_cnt #(
      .TICKS(SETTLE_TICKS)
   ) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .osc_en  (osc_q),
      .ref_tick(ref_tick),
      .stable_o(lso_stable)
   );

   always_comb begin
      pwr_view           = '0;
      pwr_view[OSC_BIT]  = osc_q;
      pwr_view[SEL_BIT]  = sel_q;
      opt_view           = '0;
      opt_view[HALT_BIT] = halt_q;
   end

   protclk_rd_mux #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .PWR_ADDR(PWR_ADDR),
      .OPT_ADDR(OPT_ADDR),
      .KEY_ADDR(KEY_ADDR),
      .RD_REG  (RD_REG)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .pwr_val(pwr_view),
      .opt_val(opt_view),
      .key_val(key_val),
      .rdata  (bus_rdata)
   );

   assign lso_en     = osc_q;
   assign clk_sel_hs = sel_q;
   assign halt2_mode = halt_q;
endmodule

// File: rtl/protclk_ctrl_chk.sv
module protclk_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic hs_osc_on,
   input logic lso_en,
   input logic clk_sel_hs,
   input logic halt2_mode,
   input logic lso_stable,
   input logic key_open
);
   // R2
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !key_open |=> ($stable(lso_en) && $stable(clk_sel_hs) && $stable(halt2_mode)));

   // R4
   lso_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_sel_hs |-> lso_en);

   // R5
   switch_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk_sel_hs) |-> ($past(hs_osc_on) && $past(lso_en)));

   // R6
   to_low_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_sel_hs) |-> $past(lso_stable));

   // R8
   stable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lso_en |=> !lso_stable);

   // R8
   stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lso_stable) |-> lso_en);
endmodule

bind protclk_ctrl protclk_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hs_osc_on (hs_osc_on),
   .lso_en    (lso_en),
   .clk_sel_hs(clk_sel_hs),
   .halt2_mode(halt2_mode),
   .lso_stable(lso_stable),
   .key_open  (key_open)
);

// File: tb/protclk_ctrl_test.sv
module protclk_ctrl_test;
   localparam int TICKS = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ref_tick = 1'b0;
   logic       hs_osc_on = 1'b1;
   logic       lso_en, clk_sel_hs, halt2_mode, lso_stable;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   protclk_ctrl #(.SETTLE_TICKS(TICKS)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick(ref_tick),
      .hs_osc_on(hs_osc_on), .lso_en(lso_en), .clk_sel_hs(clk_sel_hs),
      .halt2_mode(halt2_mode), .lso_stable(lso_stable)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic tick;
      @(negedge clk);
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 lso_en", {7'd0, lso_en}, 8'd1);
      chk("R1 clk_sel_hs", {7'd0, clk_sel_hs}, 8'd1);
      chk("R1 halt2_mode", {7'd0, halt2_mode}, 8'd0);
      chk("R1 lso_stable", {7'd0, lso_stable}, 8'd0);
      rd("R1 key", 2'd2, 8'h00);
      rd("R3 pwr read", 2'd0, 8'h05);
      rd("R10 opt read", 2'd1, 8'h00);
      rd("R10 addr3", 2'd3, 8'h00);

      // R8 stable after exactly TICKS ticks
      for (int i = 0; i < TICKS - 1; i++) tick();
      chk("R8 early", {7'd0, lso_stable}, 8'd0);
      tick();
      chk("R8 rise", {7'd0, lso_stable}, 8'd1);

      // R2 / R7 / R9 key sweep
      for (int k = 0; k < 256; k++) begin
         logic [7:0] kv;
         kv = 8'(k);
         wr(2'd2, kv);
         rd("R9 key rd", 2'd2, kv);
         wr(2'd1, 8'hFF);
         rd("R2 R7 opt gated", 2'd1, (kv == 8'h96) ? 8'h08 : 8'h00);
         rd("R9 key kept", 2'd2, kv);
         if (kv == 8'h96) wr(2'd1, 8'h00);
         else begin
            wr(2'd0, 8'h00);
            rd("R2 pwr gated", 2'd0, 8'h05);
         end
      end

      // unlock for directed checks
      wr(2'd2, 8'h96);
      wr(2'd0, 8'h01);
      rd("R5 switch to low", 2'd0, 8'h01);
      chk("R5 sel out", {7'd0, clk_sel_hs}, 8'd0);
      wr(2'd0, 8'h00);
      rd("R4 osc stop refused", 2'd0, 8'h01);
      hs_osc_on = 1'b0;
      wr(2'd0, 8'h05);
      rd("R5 hs off refuses", 2'd0, 8'h01);
      hs_osc_on = 1'b1;
      wr(2'd0, 8'h05);
      rd("R5 switch to high", 2'd0, 8'h05);
      wr(2'd0, 8'h04);
      rd("R3 osc stop", 2'd0, 8'h04);
      chk("R3 lso_en out", {7'd0, lso_en}, 8'd0);
      @(negedge clk);
      chk("R8 fall", {7'd0, lso_stable}, 8'd0);
      wr(2'd0, 8'h00);
      rd("R5 lso off refuses", 2'd0, 8'h04);
      wr(2'd0, 8'h05);
      rd("R3 osc restart", 2'd0, 8'h05);
      wr(2'd0, 8'h01);
      rd("R6 unstable refuses", 2'd0, 8'h05);
      for (int i = 0; i < TICKS - 1; i++) tick();
      chk("R8 restart early", {7'd0, lso_stable}, 8'd0);
      tick();
      chk("R8 restart rise", {7'd0, lso_stable}, 8'd1);
      wr(2'd0, 8'h01);
      rd("R6 stable accepts", 2'd0, 8'h01);
      wr(2'd0, 8'h05);
      wr(2'd0, 8'h00);
      rd("R4 joint switch keeps osc", 2'd0, 8'h01);
      wr(2'd0, 8'hFA);
      rd("R10 pwr unused", 2'd0, 8'h01);
      wr(2'd0, 8'hFF);
      rd("R10 pwr all ones", 2'd0, 8'h05);
      wr(2'd1, 8'hF7);
      rd("R7 halt clear", 2'd1, 8'h00);
      wr(2'd1, 8'hFF);
      rd("R10 opt unused", 2'd1, 8'h08);
      chk("R7 halt out", {7'd0, halt2_mode}, 8'd1);
      rd("R9 key after writes", 2'd2, 8'h96);
      wr(2'd3, 8'hFF);
      rd("R10 addr3 write", 2'd3, 8'h00);
      rd("R9 addr3 no key", 2'd2, 8'h96);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule